// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Dispatcher

This block sits between a decoded-instruction queue and two in-order integer pipes, a primary pipe that accepts any instruction and a secondary pipe that accepts only instructions marked simple. Each cycle it looks at the two oldest queue entries and decides whether both go out together or only the oldest goes. The older instruction always goes to the primary pipe. A follower that cannot join it is held back and becomes the oldest entry in the next cycle. The pairing decision is made entirely by hardware from the register fields and the class flag.

The queue head is a stream. The per-entry valid bits play the role of `valid`. The pop count plays the role of `ready` and tells the queue how many entries it consumed this cycle. Back-pressure from the pipes arrives on `stall`. While it is high nothing issues, the pop count is zero, and every in-flight stage holds its contents. `flush` empties every stage, stops issue for that cycle and also gives a pop count of zero.

Issued instructions are tracked through the stages D1, D2, EX and WB. Both instructions of a pair move in lockstep. A retire strobe and tag appear for each pipe when its instruction leaves WB. In a cycle where both pipes retire, the primary-pipe result is the older of the two.

Top module: `pair_dispatch`

## Requirements
- R1: When `h0_valid` is 1 and neither `stall` nor `flush` is 1, `u_valid` is 1 and `u_tag` equals `h0_tag` in the same cycle.
- R2: `v_valid` is 1 only if `h1_simple` is 1, both head entries are valid and `u_valid` is 1. When it is 1, `v_tag` equals `h1_tag`.
- R3: A pair is refused when `h0_dst` equals `h1_srca`, `h1_srcb` or `h1_dst`. In that case only the oldest entry issues.
- R4: `pop_cnt` (2 bits: 0, 1 or 2) equals the number of instructions issued in that cycle.
- R5: When `h0_valid` is 0, nothing issues and `pop_cnt` is 0, whatever the state of entry 1.
- R6: While `stall` is 1 and `flush` is 0: nothing issues, `pop_cnt` is 0, no retire strobe is raised, and every stage keeps its contents.
- R7: When `flush` is 1: nothing issues and `pop_cnt` is 0 in that cycle. Every instruction in flight before the next rising edge is discarded and never raises a retire strobe.
- R8: An instruction issued in a cycle raises its retire strobe with its own tag in the cycle that follows the fourth non-stalled rising edge, counting the edge that ends the issue cycle.
- R9: The two instructions of a pair retire in the same cycle. `ret_v_valid` is never 1 without `ret_u_valid`.
- R10: After reset, no stage holds a valid instruction and no retire strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freezes issue and all stages |
| flush | input | 1 | Clears all stages and blocks issue |
| h0_valid | input | 1 | Oldest queue entry present |
| h0_simple | input | 1 | Oldest entry is simple class |
| h0_dst | input | REG_W | Oldest entry destination register |
| h0_srca | input | REG_W | Oldest entry first source |
| h0_srcb | input | REG_W | Oldest entry second source |
| h0_tag | input | TAG_W | Oldest entry tag |
| h1_valid | input | 1 | Next queue entry present |
| h1_simple | input | 1 | Next entry is simple class |
| h1_dst | input | REG_W | Next entry destination register |
| h1_srca | input | REG_W | Next entry first source |
| h1_srcb | input | REG_W | Next entry second source |
| h1_tag | input | TAG_W | Next entry tag |
| u_valid | output | 1 | Primary pipe issue strobe |
| u_tag | output | TAG_W | Tag issued to primary pipe |
| v_valid | output | 1 | Secondary pipe issue strobe |
| v_tag | output | TAG_W | Tag issued to secondary pipe |
| pop_cnt | output | 2 | Entries consumed from the queue |
| ret_u_valid | output | 1 | Primary pipe retire strobe |
| ret_u_tag | output | TAG_W | Primary pipe retiring tag |
| ret_v_valid | output | 1 | Secondary pipe retire strobe |
| ret_v_tag | output | TAG_W | Secondary pipe retiring tag |

## Verification
The assertions assume that `stall` and `flush` are known and are driven only between clock edges. They do not assume that the queue keeps valid entries packed. The stimulus therefore deliberately presents entry 1 valid with entry 0 empty, and the dispatcher must ignore that case. Register numbers are drawn from a small range so that dependency clashes on each of the three compared fields occur often. Stall and flush are raised at random, at modest rates, and also in directed runs, so that frozen and cleared stages are both seen with pairs in flight.

// File: rtl/pair_dispatch_pkg.sv
package pair_dispatch_pkg;
  typedef enum logic [1:0] {
    POP_NONE = 2'd0,
    POP_ONE  = 2'd1,
    POP_TWO  = 2'd2
  } pop_e;

  localparam int unsigned PIPE_COUNT = 2;
  localparam int unsigned PIPE_U     = 0;
  localparam int unsigned PIPE_V     = 1;
endpackage

// File: rtl/pair_check.sv
module pair_check
  import pair_dispatch_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic             go,
  input  logic             a_valid,
  input  logic [REG_W-1:0] a_dst,
  input  logic             b_valid,
  input  logic             b_simple,
  input  logic [REG_W-1:0] b_dst,
  input  logic [REG_W-1:0] b_srca,
  input  logic [REG_W-1:0] b_srcb,
  output logic             issue_u,
  output logic             issue_v,
  output pop_e             pop
);
  logic clash_raw;
  logic clash_waw;
  logic can_pair;

  always_comb begin
    clash_raw = (a_dst == b_srca) || (a_dst == b_srcb);
    clash_waw = (a_dst == b_dst);
    can_pair  = a_valid && b_valid && b_simple && !clash_raw && !clash_waw;
    issue_u   = go && a_valid;
    issue_v   = go && can_pair;
    if (issue_v)      pop = POP_TWO;
    else if (issue_u) pop = POP_ONE;
    else              pop = POP_NONE;
  end
endmodule

// File: rtl/stage_track.sv
module stage_track #(
  parameter int unsigned NUM_STAGES = 4,
  parameter int unsigned TAG_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  input  logic             flush,
  input  logic             in_vld,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_vld,
  output logic [TAG_W-1:0] out_tag
);
  localparam int unsigned LAST = NUM_STAGES - 1;

  logic [NUM_STAGES-1:0] vld;
  logic [TAG_W-1:0]      tag [NUM_STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      for (int s = 0; s < NUM_STAGES; s++) tag[s] <= '0;
    end else if (flush) begin
      vld <= '0;
    end else if (!stall) begin
      vld[0] <= in_vld;
      tag[0] <= in_tag;
      for (int s = 1; s < NUM_STAGES; s++) begin
        vld[s] <= vld[s-1];
        tag[s] <= tag[s-1];
      end
    end
  end

  assign out_vld = vld[LAST] && !stall && !flush;
  assign out_tag = tag[LAST];

  // R7: a flush leaves no stage occupied
  a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld == '0));

  // R6: stall holds every stage
  a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !flush) |=> ($stable(vld) && $stable(tag[LAST])));
endmodule

// File: rtl/pair_dispatch.sv
module pair_dispatch
  import pair_dispatch_pkg::*;
#(
  parameter int unsigned REG_W      = 5,
  parameter int unsigned TAG_W      = 6,
  parameter int unsigned NUM_STAGES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  input  logic             flush,
  input  logic             h0_valid,
  input  logic             h0_simple,
  input  logic [REG_W-1:0] h0_dst,
  input  logic [REG_W-1:0] h0_srca,
  input  logic [REG_W-1:0] h0_srcb,
  input  logic [TAG_W-1:0] h0_tag,
  input  logic             h1_valid,
  input  logic             h1_simple,
  input  logic [REG_W-1:0] h1_dst,
  input  logic [REG_W-1:0] h1_srca,
  input  logic [REG_W-1:0] h1_srcb,
  input  logic [TAG_W-1:0] h1_tag,
  output logic             u_valid,
  output logic [TAG_W-1:0] u_tag,
  output logic             v_valid,
  output logic [TAG_W-1:0] v_tag,
  output logic [1:0]       pop_cnt,
  output logic             ret_u_valid,
  output logic [TAG_W-1:0] ret_u_tag,
  output logic             ret_v_valid,
  output logic [TAG_W-1:0] ret_v_tag
);
  logic go;
  pop_e pop;
  logic             iss_vld [PIPE_COUNT];
  logic [TAG_W-1:0] iss_tag [PIPE_COUNT];
  logic             ret_vld [PIPE_COUNT];
  logic [TAG_W-1:0] ret_tag [PIPE_COUNT];
  logic             h0_simple_unused;

  assign go = !stall && !flush;
  assign h0_simple_unused = h0_simple ^ (|h0_srca) ^ (|h0_srcb);

  pair_check #(.REG_W(REG_W)) u_pair_check (
    .go       (go),
    .a_valid  (h0_valid),
    .a_dst    (h0_dst),
    .b_valid  (h1_valid),
    .b_simple (h1_simple),
    .b_dst    (h1_dst),
    .b_srca   (h1_srca),
    .b_srcb   (h1_srcb),
    .issue_u  (iss_vld[PIPE_U]),
    .issue_v  (iss_vld[PIPE_V]),
    .pop      (pop)
  );

  assign iss_tag[PIPE_U] = h0_tag;
  assign iss_tag[PIPE_V] = h1_tag;

  generate
    for (genvar p = 0; p < PIPE_COUNT; p++) begin : g_pipe
      stage_track #(.NUM_STAGES(NUM_STAGES), .TAG_W(TAG_W)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .stall   (stall),
        .flush   (flush),
        .in_vld  (iss_vld[p]),
        .in_tag  (iss_tag[p]),
        .out_vld (ret_vld[p]),
        .out_tag (ret_tag[p])
      );
    end
  endgenerate

  assign u_valid     = iss_vld[PIPE_U];
  assign u_tag       = iss_tag[PIPE_U];
  assign v_valid     = iss_vld[PIPE_V];
  assign v_tag       = iss_tag[PIPE_V];
  assign pop_cnt     = pop;
  assign ret_u_valid = ret_vld[PIPE_U];
  assign ret_u_tag   = ret_tag[PIPE_U];
  assign ret_v_valid = ret_vld[PIPE_V];
  assign ret_v_tag   = ret_tag[PIPE_V];

  // R2: the secondary pipe never issues alone or a non-simple instruction
  a_r2_v_needs_u: assert property (@(posedge clk) disable iff (!rst_n)
    v_valid |-> (u_valid && h1_simple));

  // R4: pop count agrees with issue strobes
  a_r4_pop_matches: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({u_valid, v_valid}) == pop_cnt);

  // R6 / R7: blocked cycles consume nothing
  a_r6_no_pop_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (stall || flush) |-> (pop_cnt == 2'd0 && !u_valid));

  // R9: pairs retire in lockstep
  a_r9_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
    ret_v_valid |-> ret_u_valid);
endmodule

// File: tb/pair_dispatch_bench.sv
module pair_dispatch_bench;
  localparam int REG_W = 5;
  localparam int TAG_W = 6;
  localparam int NS    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stall = 1'b0, flush = 1'b0;
  logic h0_valid = 1'b0, h0_simple = 1'b0, h1_valid = 1'b0, h1_simple = 1'b0;
  logic [REG_W-1:0] h0_dst = '0, h0_srca = '0, h0_srcb = '0;
  logic [REG_W-1:0] h1_dst = '0, h1_srca = '0, h1_srcb = '0;
  logic [TAG_W-1:0] h0_tag = '0, h1_tag = '0;
  logic u_valid, v_valid, ret_u_valid, ret_v_valid;
  logic [TAG_W-1:0] u_tag, v_tag, ret_u_tag, ret_v_tag;
  logic [1:0] pop_cnt;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic             mu_v [NS];
  logic [TAG_W-1:0] mu_t [NS];
  logic             mv_v [NS];
  logic [TAG_W-1:0] mv_t [NS];

  always #5 clk = ~clk;

  pair_dispatch u_pair_dispatch (
    .clk(clk), .rst_n(rst_n), .stall(stall), .flush(flush),
    .h0_valid(h0_valid), .h0_simple(h0_simple), .h0_dst(h0_dst),
    .h0_srca(h0_srca), .h0_srcb(h0_srcb), .h0_tag(h0_tag),
    .h1_valid(h1_valid), .h1_simple(h1_simple), .h1_dst(h1_dst),
    .h1_srca(h1_srca), .h1_srcb(h1_srcb), .h1_tag(h1_tag),
    .u_valid(u_valid), .u_tag(u_tag), .v_valid(v_valid), .v_tag(v_tag),
    .pop_cnt(pop_cnt),
    .ret_u_valid(ret_u_valid), .ret_u_tag(ret_u_tag),
    .ret_v_valid(ret_v_valid), .ret_v_tag(ret_v_tag)
  );

  function automatic bit exp_u();
    return !stall && !flush && h0_valid;
  endfunction

  function automatic bit exp_v();
    return !stall && !flush && h0_valid && h1_valid && h1_simple &&
           h0_dst != h1_srca && h0_dst != h1_srcb && h0_dst != h1_dst;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_model();
    for (int s = 0; s < NS; s++) begin
      mu_v[s] = 1'b0; mu_t[s] = '0; mv_v[s] = 1'b0; mv_t[s] = '0;
    end
  endtask

  // one cycle: inputs already driven after a falling edge
  task automatic step();
    bit eu, ev, ru, rv;
    #1;
    eu = exp_u();
    ev = exp_v();
    chk(u_valid == eu, "R1 u_valid", u_valid, eu);
    if (eu) chk(u_tag == h0_tag, "R1 u_tag", u_tag, h0_tag);
    chk(v_valid == ev, "R2/R3 v_valid", v_valid, ev);
    if (ev) chk(v_tag == h1_tag, "R2 v_tag", v_tag, h1_tag);
    chk(pop_cnt == (eu + ev), "R4 pop_cnt", pop_cnt, eu + ev);
    if (!h0_valid) chk(pop_cnt == 0, "R5 pop_cnt", pop_cnt, 0);
    ru = mu_v[NS-1] && !stall && !flush;
    rv = mv_v[NS-1] && !stall && !flush;
    if (stall || flush) chk(!ret_u_valid, "R6/R7 ret_u_valid", ret_u_valid, 0);
    chk(ret_u_valid == ru, "R8 ret_u_valid", ret_u_valid, ru);
    chk(ret_v_valid == rv, "R9 ret_v_valid", ret_v_valid, rv);
    if (ru) chk(ret_u_tag == mu_t[NS-1], "R8 ret_u_tag", ret_u_tag, mu_t[NS-1]);
    if (rv) chk(ret_v_tag == mv_t[NS-1], "R9 ret_v_tag", ret_v_tag, mv_t[NS-1]);
    @(posedge clk);
    if (flush) clear_model();
    else if (!stall) begin
      for (int s = NS-1; s > 0; s--) begin
        mu_v[s] = mu_v[s-1]; mu_t[s] = mu_t[s-1];
        mv_v[s] = mv_v[s-1]; mv_t[s] = mv_t[s-1];
      end
      mu_v[0] = eu; mu_t[0] = h0_tag;
      mv_v[0] = ev; mv_t[0] = h1_tag;
    end
  endtask

  task automatic set_heads(input bit v0, input bit s0, input int d0, input int a0, input int b0,
                           input bit v1, input bit s1, input int d1, input int a1, input int b1);
    h0_valid = v0; h0_simple = s0; h0_dst = d0[REG_W-1:0];
    h0_srca = a0[REG_W-1:0]; h0_srcb = b0[REG_W-1:0]; h0_tag = h0_tag + 6'd2;
    h1_valid = v1; h1_simple = s1; h1_dst = d1[REG_W-1:0];
    h1_srca = a1[REG_W-1:0]; h1_srcb = b1[REG_W-1:0]; h1_tag = h0_tag + 6'd1;
  endtask

  task automatic directed(input bit v0, input bit s0, input int d0, input int a0, input int b0,
                          input bit v1, input bit s1, input int d1, input int a1, input int b1,
                          input bit st, input bit fl);
    @(negedge clk);
    set_heads(v0, s0, d0, a0, b0, v1, s1, d1, a1, b1);
    stall = st; flush = fl;
    step();
  endtask

  initial begin
    clear_model();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state
    #1;
    chk(!ret_u_valid && !ret_v_valid, "R10 retire after reset", ret_u_valid, 0);
    chk(pop_cnt == 0, "R10 pop after reset", pop_cnt, 0);
    step();
    // clean pair, then each hazard field (R3), non-simple follower, empty head (R5)
    directed(1,1,1,2,3, 1,1,4,5,6, 0,0);
    directed(1,0,7,2,3, 1,1,4,7,6, 0,0);
    directed(1,1,7,2,3, 1,1,4,5,7, 0,0);
    directed(1,1,7,2,3, 1,1,7,5,6, 0,0);
    directed(1,1,1,2,3, 1,0,4,5,6, 0,0);
    directed(0,1,1,2,3, 1,1,4,5,6, 0,0);
    directed(1,1,1,2,3, 0,1,4,5,6, 0,0);
    // stall with pairs in flight (R6), then drain (R8)
    directed(1,1,1,2,3, 1,1,4,5,6, 1,0);
    directed(1,1,1,2,3, 1,1,4,5,6, 1,0);
    repeat (6) directed(0,0,0,0,0, 0,0,0,0,0, 0,0);
    // fill then flush (R7): nothing issued earlier may retire
    directed(1,1,1,2,3, 1,1,4,5,6, 0,0);
    directed(1,1,9,2,3, 1,1,4,5,6, 0,0);
    directed(1,1,1,2,3, 1,1,4,5,6, 0,1);
    repeat (6) directed(0,0,0,0,0, 0,0,0,0,0, 0,0);
    // constrained random
    void'($urandom(32'd20240517));
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      set_heads($urandom_range(0,9) != 0, $urandom_range(0,2) != 0,
                $urandom_range(0,3), $urandom_range(0,3), $urandom_range(0,3),
                $urandom_range(0,4) != 0, $urandom_range(0,3) != 0,
                $urandom_range(0,3), $urandom_range(0,3), $urandom_range(0,3));
      stall = ($urandom_range(0,7) == 0);
      flush = ($urandom_range(0,29) == 0);
      step();
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule